// File: doc/BRIEF.md
# Half-Duplex Multi-Wire Serial Slave Front End

This block is the receive and transmit front end of a half-duplex serial slave. A master frames each transaction with an active-low select. Within the frame it sends an 8-bit command, then, for transfer commands, an 8-bit address, a turnaround gap and a data phase of any length. The upper nibble of the command selects how many of the four data wires the address and data phases use, and the lower nibble selects the operation. A sticky quad state, entered and left by two dedicated commands, widens the command phase itself to four wires.

The serial clock, select and data wires are brought into the system clock domain through a synchronizer, and their edges are detected there. The back end sees a parallel interface: the received command and address, a header strobe at the start of the data phase, a byte stream with a valid strobe for writes, and a byte source with a ready strobe for reads. Commands that carry no address or data raise a one-cycle event strobe when the frame closes.

Top module: `spi_hd_slave`

## Requirements
- R1: Input bits are taken on each rising serial clock edge, most significant bit or nibble first; the command and address are 8 bits each and come out on `cmd_byte` and `addr_byte` once the frame is over.
- R2: Outside the quad state, a command with lower nibble 1 to 4 takes its wire counts (address/data) from its upper nibble: 0x0 gives 1/1, 0x1 gives 1/2, 0x5 gives 2/2, 0x2 gives 1/4, 0xA gives 4/4. One wire uses line 0 for input and line 1 for output; two wires use lines 1:0 with line 1 more significant; four wires use lines 3:0 with line 3 most significant.
- R3: The turnaround gap lasts 1 serial clock for the 1/1 form and 4 for every other form; no output enable is active during it.
- R4: Lower nibble 1 or 3 is a write: each complete data byte gives one `wr_valid` cycle with the byte on `wr_data`, and the slave drives no line.
- R5: Lower nibble 2 or 4 is a read: during the data phase the output enable is 4'b0010, 4'b0011 or 4'b1111 for one, two or four wires, and each beat is launched on a falling serial clock edge.
- R6: `rd_data` is taken in each cycle where `rd_ready` is high: once at the last turnaround edge and again after each complete byte, so a read of n whole bytes gives n+1 `rd_ready` cycles.
- R7: `hdr_valid` is high for exactly one cycle at the start of each data phase.
- R8: Commands 0x05, 0x07, 0x08, 0x09 and 0x0A raise `evt_valid` for one cycle with the command on `evt_code` when the select is released.
- R9: Command 0x06 sets the quad state and 0xDD clears it, both at select release, with no event strobe.
- R10: In the quad state the command, address and data phases all use four wires with a 4-cycle gap, and transfer commands with upper nibble 0x0 or 0xA are accepted.
- R11: Releasing the select at any point ends the transaction with no further strobe and returns to command reception; the quad state is kept.
- R12: Any other command makes the slave ignore the rest of the frame: no output enable, no write, header or event strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_io_in | input | 4 | Data wires as seen at the pads |
| spi_io_out | output | 4 | Values driven onto the data wires |
| spi_io_oe | output | 4 | Per-wire output enable |
| cmd_byte | output | 8 | Last received command |
| addr_byte | output | 8 | Last received address |
| hdr_valid | output | 1 | One-cycle strobe when the data phase begins |
| wr_data | output | 8 | Received write byte |
| wr_valid | output | 1 | One-cycle strobe for `wr_data` |
| rd_data | input | 8 | Next byte to send on a read |
| rd_ready | output | 1 | `rd_data` is taken in this cycle |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 8 | Command that raised the event |
| qpi_active | output | 1 | Quad state flag |

## Verification
Every serial edge reaches the logic three system clocks after the pin moves (two synchronizer stages and one edge register), so a launched read beat is on the pins about three clocks after the falling edge; the bench holds each serial half period for six clocks and samples the data and enable wires just before it raises the clock. Strobes such as `wr_valid`, `rd_ready` and `hdr_valid` appear about four clocks after the rising edge that completes their phase, and events or quad changes a few clocks after select release. The bench therefore counts strobes in a monitor on every clock and compares the counts and logged bytes only after the select has been high for ten clocks.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;

  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int DUM_W  = 3;

  localparam logic [7:0] CMD_QUAD_ON  = 8'h06;
  localparam logic [7:0] CMD_QUAD_OFF = 8'hDD;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_GAP, PH_DATA, PH_HOLD, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    KIND_BAD, KIND_XFER, KIND_EVENT, KIND_MODE
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic               rd;
    logic [2:0]         aw;
    logic [2:0]         dw;
    logic [DUM_W-1:0]   gap;
  } cmd_cfg_t;

  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] s,
                                                 input logic [LANES-1:0] io,
                                                 input logic [2:0] w);
    case (w)
      3'd2:    return {s[BYTE_W-3:0], io[1:0]};
      3'd4:    return {s[BYTE_W-5:0], io[3:0]};
      default: return {s[BYTE_W-2:0], io[0]};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out(input logic [BYTE_W-1:0] s,
                                                  input logic [2:0] w);
    case (w)
      3'd2:    return {s[BYTE_W-3:0], 2'b00};
      3'd4:    return {s[BYTE_W-5:0], 4'b0000};
      default: return {s[BYTE_W-2:0], 1'b0};
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_drive(input logic [BYTE_W-1:0] s,
                                                  input logic [2:0] w);
    case (w)
      3'd2:    return {2'b00, s[BYTE_W-1:BYTE_W-2]};
      3'd4:    return s[BYTE_W-1:BYTE_W-4];
      default: return {2'b00, s[BYTE_W-1], 1'b0};
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] w);
    case (w)
      3'd2:    return 4'b0011;
      3'd4:    return 4'b1111;
      default: return 4'b0010;
    endcase
  endfunction

endpackage

// File: rtl/spi_hd_sync.sv
module spi_hd_sync #(
  parameter int          W      = 6,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST;
        else        st[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= RST;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spi_hd_decode.sv
module spi_hd_decode
  import spi_hd_pkg::*;
#(
  parameter int GAP_SINGLE = 1,
  parameter int GAP_MULTI  = 4
) (
  input  logic [BYTE_W-1:0] cmd,
  input  logic              quad,
  output cmd_cfg_t          cfg
);

  localparam logic [DUM_W-1:0] GAP_S = DUM_W'(GAP_SINGLE);
  localparam logic [DUM_W-1:0] GAP_M = DUM_W'(GAP_MULTI);

  logic [3:0] hi, lo;
  assign hi = cmd[7:4];
  assign lo = cmd[3:0];

  always_comb begin
    cfg.kind = KIND_BAD;
    cfg.rd   = ~lo[0];
    cfg.aw   = 3'd1;
    cfg.dw   = 3'd1;
    cfg.gap  = GAP_S;
    if (cmd == CMD_QUAD_ON || cmd == CMD_QUAD_OFF) begin
      cfg.kind = KIND_MODE;
    end else if (hi == 4'h0 && (lo == 4'h5 || lo == 4'h7 || lo == 4'h8 ||
                                lo == 4'h9 || lo == 4'hA)) begin
      cfg.kind = KIND_EVENT;
    end else if (lo >= 4'h1 && lo <= 4'h4) begin
      if (quad) begin
        if (hi == 4'h0 || hi == 4'hA) begin
          cfg.kind = KIND_XFER;
          cfg.aw   = 3'd4;
          cfg.dw   = 3'd4;
          cfg.gap  = GAP_M;
        end
      end else begin
        case (hi)
          4'h0: begin cfg.kind = KIND_XFER; end
          4'h1: begin cfg.kind = KIND_XFER; cfg.dw = 3'd2; cfg.gap = GAP_M; end
          4'h5: begin cfg.kind = KIND_XFER; cfg.aw = 3'd2; cfg.dw = 3'd2; cfg.gap = GAP_M; end
          4'h2: begin cfg.kind = KIND_XFER; cfg.dw = 3'd4; cfg.gap = GAP_M; end
          4'hA: begin cfg.kind = KIND_XFER; cfg.aw = 3'd4; cfg.dw = 3'd4; cfg.gap = GAP_M; end
          default: cfg.kind = KIND_BAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_hd_phase.sv
module spi_hd_phase
  import spi_hd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sel_on,
  input  logic              sel_release,
  input  logic [LANES-1:0]  io_s,
  input  cmd_cfg_t          cfg,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] asm_byte,
  output logic              quad,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] addr_q,
  output logic              hdr_q,
  output logic [BYTE_W-1:0] wdat_q,
  output logic              wval_q,
  output logic              rrdy_q,
  output logic [LANES-1:0]  out_q,
  output logic [LANES-1:0]  oe,
  output logic              evt_q,
  output logic [BYTE_W-1:0] evt_code_q
);

  phase_e            st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_inc;
  logic [BYTE_W-1:0] sh_q, sh_n, osh_q, osh_n;
  logic [DUM_W-1:0]  gap_q, gap_n, gcnt_q, gcnt_n;
  logic              rd_q, rd_n, quad_n;
  logic [2:0]        aw_q, aw_n, dw_q, dw_n, w_cur;
  logic [BYTE_W-1:0] cmd_n, addr_n, wdat_n, evt_code_n;
  logic              hdr_n, wval_n, rrdy_n, evt_n;
  logic [LANES-1:0]  out_n;
  logic              byte_done;

  always_comb begin
    case (st_q)
      PH_CMD:  w_cur = quad ? 3'd4 : 3'd1;
      PH_ADDR: w_cur = aw_q;
      PH_DATA: w_cur = dw_q;
      default: w_cur = 3'd1;
    endcase
  end

  assign asm_byte  = shift_in(sh_q, io_s, w_cur);
  assign cnt_inc   = cnt_q + CNT_W'(w_cur);
  assign byte_done = (cnt_inc == CNT_W'(BYTE_W));
  assign oe        = (st_q == PH_DATA && rd_q) ? lane_mask(dw_q) : '0;

  always_comb begin
    st_n = st_q;     cnt_n = cnt_q;   sh_n = sh_q;     osh_n = osh_q;
    gap_n = gap_q;   gcnt_n = gcnt_q; rd_n = rd_q;     aw_n = aw_q;
    dw_n = dw_q;     quad_n = quad;   cmd_n = cmd_q;   addr_n = addr_q;
    wdat_n = wdat_q; out_n = out_q;   evt_code_n = evt_code_q;
    hdr_n = 1'b0;    wval_n = 1'b0;   rrdy_n = 1'b0;   evt_n = 1'b0;

    if (!sel_on) begin
      st_n  = PH_CMD;
      cnt_n = '0;
      if (sel_release && st_q == PH_HOLD) begin
        if (cmd_q == CMD_QUAD_ON)       quad_n = 1'b1;
        else if (cmd_q == CMD_QUAD_OFF) quad_n = 1'b0;
        else begin
          evt_n      = 1'b1;
          evt_code_n = cmd_q;
        end
      end
    end else if (sclk_rise) begin
      case (st_q)
        PH_CMD: begin
          sh_n  = asm_byte;
          cnt_n = cnt_inc;
          if (byte_done) begin
            cnt_n = '0;
            cmd_n = asm_byte;
            rd_n  = cfg.rd;
            aw_n  = cfg.aw;
            dw_n  = cfg.dw;
            gap_n = cfg.gap;
            case (cfg.kind)
              KIND_XFER:  st_n = PH_ADDR;
              KIND_EVENT: st_n = PH_HOLD;
              KIND_MODE:  st_n = PH_HOLD;
              default:    st_n = PH_SKIP;
            endcase
          end
        end
        PH_ADDR: begin
          sh_n  = asm_byte;
          cnt_n = cnt_inc;
          if (byte_done) begin
            cnt_n  = '0;
            addr_n = asm_byte;
            gcnt_n = gap_q;
            st_n   = PH_GAP;
          end
        end
        PH_GAP: begin
          if (gcnt_q <= DUM_W'(1)) begin
            st_n  = PH_DATA;
            hdr_n = 1'b1;
            cnt_n = '0;
            if (rd_q) begin
              osh_n  = rd_data;
              rrdy_n = 1'b1;
            end
          end else begin
            gcnt_n = gcnt_q - DUM_W'(1);
          end
        end
        PH_DATA: begin
          cnt_n = cnt_inc;
          if (!rd_q) sh_n = asm_byte;
          if (byte_done) begin
            cnt_n = '0;
            if (rd_q) begin
              osh_n  = rd_data;
              rrdy_n = 1'b1;
            end else begin
              wdat_n = asm_byte;
              wval_n = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end else if (sclk_fall && st_q == PH_DATA && rd_q) begin
      out_n = lane_drive(osh_q, dw_q);
      osh_n = shift_out(osh_q, dw_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PH_CMD;  cnt_q <= '0;  sh_q <= '0;   osh_q <= '0;
      gap_q <= '0;     gcnt_q <= '0; rd_q <= 1'b0; aw_q <= 3'd1;
      dw_q <= 3'd1;    quad <= 1'b0; cmd_q <= '0;  addr_q <= '0;
      wdat_q <= '0;    out_q <= '0;  evt_code_q <= '0;
      hdr_q <= 1'b0;   wval_q <= 1'b0; rrdy_q <= 1'b0; evt_q <= 1'b0;
    end else begin
      st_q <= st_n;    cnt_q <= cnt_n;   sh_q <= sh_n;   osh_q <= osh_n;
      gap_q <= gap_n;  gcnt_q <= gcnt_n; rd_q <= rd_n;   aw_q <= aw_n;
      dw_q <= dw_n;    quad <= quad_n;   cmd_q <= cmd_n; addr_q <= addr_n;
      wdat_q <= wdat_n; out_q <= out_n;  evt_code_q <= evt_code_n;
      hdr_q <= hdr_n;  wval_q <= wval_n; rrdy_q <= rrdy_n; evt_q <= evt_n;
    end
  end

endmodule

// File: rtl/spi_hd_slave.sv
module spi_hd_slave
  import spi_hd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAP_SINGLE  = 1,
  parameter int GAP_MULTI   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic [LANES-1:0]  spi_io_in,
  output logic [LANES-1:0]  spi_io_out,
  output logic [LANES-1:0]  spi_io_oe,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] addr_byte,
  output logic              hdr_valid,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              rd_ready,
  output logic              evt_valid,
  output logic [BYTE_W-1:0] evt_code,
  output logic              qpi_active
);

  localparam int SW = LANES + 2;

  logic          rst_m, rst_core_n;
  logic [SW-1:0] pins_s;
  logic          cs_s, sclk_s, cs_d, sclk_d;
  logic [LANES-1:0] io_s;
  logic [BYTE_W-1:0] asm_byte;
  cmd_cfg_t      cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_core_n <= rst_m;
    end
  end

  spi_hd_sync #(
    .W      (SW),
    .STAGES (SYNC_STAGES),
    .RST    ({1'b1, {(SW-1){1'b0}}})
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({spi_cs_n, spi_sclk, spi_io_in}),
    .q     (pins_s)
  );

  assign cs_s   = pins_s[SW-1];
  assign sclk_s = pins_s[SW-2];
  assign io_s   = pins_s[LANES-1:0];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  spi_hd_decode #(
    .GAP_SINGLE (GAP_SINGLE),
    .GAP_MULTI  (GAP_MULTI)
  ) u_dec (
    .cmd  (asm_byte),
    .quad (qpi_active),
    .cfg  (cfg)
  );

  spi_hd_phase u_phase (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .sclk_rise   (sclk_s & ~sclk_d),
    .sclk_fall   (~sclk_s & sclk_d),
    .sel_on      (~cs_s),
    .sel_release (cs_s & ~cs_d),
    .io_s        (io_s),
    .cfg         (cfg),
    .rd_data     (rd_data),
    .asm_byte    (asm_byte),
    .quad        (qpi_active),
    .cmd_q       (cmd_byte),
    .addr_q      (addr_byte),
    .hdr_q       (hdr_valid),
    .wdat_q      (wr_data),
    .wval_q      (wr_valid),
    .rrdy_q      (rd_ready),
    .out_q       (spi_io_out),
    .oe          (spi_io_oe),
    .evt_q       (evt_valid),
    .evt_code_q  (evt_code)
  );

endmodule

// File: rtl/spi_hd_slave_chk.sv
module spi_hd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic [3:0] spi_io_oe,
  input logic       wr_valid,
  input logic       rd_ready,
  input logic       hdr_valid,
  input logic       evt_valid,
  input logic       qpi_active
);

  // R5
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_io_oe == 4'b0000 || spi_io_oe == 4'b0010 ||
    spi_io_oe == 4'b0011 || spi_io_oe == 4'b1111);

  // R4
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> spi_io_oe == 4'b0000);

  // R6
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

  // R7
  hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R8
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R9
  quad_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(qpi_active) |-> $past(spi_cs_n));

  // R8
  evt_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !wr_valid && !rd_ready && !hdr_valid);

endmodule

bind spi_hd_slave spi_hd_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n   (spi_cs_n),
  .spi_io_oe  (spi_io_oe),
  .wr_valid   (wr_valid),
  .rd_ready   (rd_ready),
  .hdr_valid  (hdr_valid),
  .evt_valid  (evt_valid),
  .qpi_active (qpi_active)
);

// File: tb/spi_hd_slave_test.sv
module spi_hd_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic [3:0] io_in = 4'h0;
  logic [3:0] io_out, io_oe;
  logic [7:0] cmd_byte, addr_byte, wr_data, rd_data, evt_code;
  logic       hdr_valid, wr_valid, rd_ready, evt_valid, qpi_active;

  int checks = 0, failures = 0;
  int wr_cnt = 0, hdr_cnt = 0, rr_cnt = 0, evt_cnt = 0;
  logic [7:0] evt_last = 8'h00;
  logic [7:0] wr_log [64];
  logic [7:0] wbuf [4];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] src_byte(input int i);
    return 8'(i * 29 + 8'h4B);
  endfunction

  assign rd_data = src_byte(rr_cnt);

  spi_hd_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_io_in(io_in), .spi_io_out(io_out), .spi_io_oe(io_oe),
    .cmd_byte(cmd_byte), .addr_byte(addr_byte), .hdr_valid(hdr_valid),
    .wr_data(wr_data), .wr_valid(wr_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .evt_valid(evt_valid), .evt_code(evt_code),
    .qpi_active(qpi_active)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      wr_log[wr_cnt % 64] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (hdr_valid) hdr_cnt <= hdr_cnt + 1;
    if (rd_ready)  rr_cnt  <= rr_cnt + 1;
    if (evt_valid) begin
      evt_cnt  <= evt_cnt + 1;
      evt_last <= evt_code;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic beat(input logic [3:0] d, output logic [3:0] q, output logic [3:0] oe);
    io_in = d;
    wait_clk(HALF);
    q  = io_out;
    oe = io_oe;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic sel_low();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic sel_high();
    wait_clk(2);
    cs_n = 1'b1;
    wait_clk(10);
  endtask

  function automatic logic [3:0] mask_of(input int w);
    return (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic send_byte(input int w, input logic [7:0] b, output bit oe_seen);
    logic [3:0] q, oe;
    logic [7:0] s = b;
    oe_seen = 1'b0;
    for (int i = 0; i < 8 / w; i++) begin
      beat((w == 1) ? {3'b0, s[7]} : (w == 2) ? {2'b0, s[7:6]} : s[7:4], q, oe);
      if (oe != 4'h0) oe_seen = 1'b1;
      s = s << w;
    end
  endtask

  task automatic recv_byte(input int w, output logic [7:0] b, output bit oe_bad);
    logic [3:0] q, oe;
    b = 8'h00;
    oe_bad = 1'b0;
    for (int i = 0; i < 8 / w; i++) begin
      beat(4'h0, q, oe);
      if (oe != mask_of(w)) oe_bad = 1'b1;
      b = (w == 1) ? {b[6:0], q[1]} : (w == 2) ? {b[5:0], q[1:0]} : {b[3:0], q[3:0]};
    end
  endtask

  task automatic run_xfer(input string req, input logic [7:0] cmd, input int cw,
                          input int aw, input int dw, input int ngap, input bit rd,
                          input logic [7:0] addr, input int nbytes);
    int hdr0 = hdr_cnt, wr0 = wr_cnt, rr0 = rr_cnt;
    bit seen, bad, gap_oe = 1'b0, data_oe_bad = 1'b0;
    logic [3:0] q, oe;
    logic [7:0] b;
    sel_low();
    send_byte(cw, cmd, seen);
    send_byte(aw, addr, seen);
    for (int g = 0; g < ngap; g++) begin
      beat(4'h0, q, oe);
      if (oe != 4'h0) gap_oe = 1'b1;
    end
    for (int k = 0; k < nbytes; k++) begin
      if (rd) begin
        recv_byte(dw, b, bad);
        if (bad) data_oe_bad = 1'b1;
        chk(b == src_byte(rr0 + k), "R5", "read byte", b, src_byte(rr0 + k));
      end else begin
        send_byte(dw, wbuf[k], seen);
        if (seen) data_oe_bad = 1'b1;
      end
    end
    sel_high();
    chk(cmd_byte == cmd, "R1", "command", cmd_byte, cmd);
    chk(addr_byte == addr, "R1", "address", addr_byte, addr);
    chk(!gap_oe, "R3", "enable in gap", gap_oe, 0);
    chk(!data_oe_bad, rd ? "R5" : "R4", "data enable", data_oe_bad, 0);
    chk(hdr_cnt - hdr0 == 1, "R7", "header strobes", hdr_cnt - hdr0, 1);
    if (rd) begin
      chk(rr_cnt - rr0 == nbytes + 1, "R6", "take strobes", rr_cnt - rr0, nbytes + 1);
    end else begin
      chk(wr_cnt - wr0 == nbytes, "R4", "write strobes", wr_cnt - wr0, nbytes);
      for (int k = 0; k < nbytes; k++)
        chk(wr_log[(wr0 + k) % 64] == wbuf[k], "R4", "write byte",
            wr_log[(wr0 + k) % 64], wbuf[k]);
    end
    chk(1'b1, req, "scenario", 0, 0);
  endtask

  task automatic simple_cmd(input int w, input logic [7:0] c);
    bit seen;
    sel_low();
    send_byte(w, c, seen);
    sel_high();
  endtask

  task automatic t_reset();
    chk(io_oe == 4'h0, "R5", "reset enable", io_oe, 0);
    chk(qpi_active == 1'b0, "R9", "reset quad", qpi_active, 0);
    chk(!wr_valid && !evt_valid && !hdr_valid, "R4", "reset strobes", 0, 0);
  endtask

  task automatic t_writes();
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    run_xfer("R2", 8'h01, 1, 1, 1, 1, 1'b0, 8'h3C, 2);
    wbuf[0] = 8'hC3; wbuf[1] = 8'h1E; wbuf[2] = 8'h96;
    run_xfer("R2", 8'hA3, 1, 4, 4, 4, 1'b0, 8'h77, 3);
    wbuf[0] = 8'h6D;
    run_xfer("R2", 8'h51, 1, 2, 2, 4, 1'b0, 8'hE1, 1);
  endtask

  task automatic t_reads();
    run_xfer("R2", 8'h02, 1, 1, 1, 1, 1'b1, 8'h10, 2);
    run_xfer("R2", 8'h12, 1, 1, 2, 4, 1'b1, 8'h81, 2);
    run_xfer("R2", 8'h54, 1, 2, 2, 4, 1'b1, 8'h2B, 3);
    run_xfer("R2", 8'h24, 1, 1, 4, 4, 1'b1, 8'hF0, 2);
  endtask

  task automatic t_events();
    int e0 = evt_cnt;
    simple_cmd(1, 8'h08);
    chk(evt_cnt - e0 == 1, "R8", "event count", evt_cnt - e0, 1);
    chk(evt_last == 8'h08, "R8", "event code", evt_last, 8'h08);
    simple_cmd(1, 8'h05);
    chk(evt_cnt - e0 == 2, "R8", "event count", evt_cnt - e0, 2);
    chk(evt_last == 8'h05, "R8", "event code", evt_last, 8'h05);
  endtask

  task automatic t_quad();
    int e0 = evt_cnt;
    simple_cmd(1, 8'h06);
    chk(qpi_active == 1'b1, "R9", "quad set", qpi_active, 1);
    chk(evt_cnt == e0, "R9", "no event on mode", evt_cnt - e0, 0);
    run_xfer("R10", 8'hA2, 4, 4, 4, 4, 1'b1, 8'h5C, 2);
    wbuf[0] = 8'h3A; wbuf[1] = 8'hC7;
    run_xfer("R10", 8'h01, 4, 4, 4, 4, 1'b0, 8'h09, 2);
    simple_cmd(4, 8'hDD);
    chk(qpi_active == 1'b0, "R9", "quad cleared", qpi_active, 0);
    chk(evt_cnt == e0, "R9", "no event on exit", evt_cnt - e0, 0);
  endtask

  task automatic t_abort();
    int h0, w0, e0;
    bit seen;
    logic [3:0] q, oe;
    simple_cmd(1, 8'h06);
    h0 = hdr_cnt; w0 = wr_cnt; e0 = evt_cnt;
    sel_low();
    send_byte(4, 8'hA1, seen);
    beat(4'h7, q, oe);
    sel_high();
    chk(qpi_active == 1'b1, "R11", "quad kept", qpi_active, 1);
    chk(hdr_cnt == h0 && wr_cnt == w0 && evt_cnt == e0, "R11", "no strobe after abort",
        hdr_cnt - h0 + wr_cnt - w0 + evt_cnt - e0, 0);
    simple_cmd(4, 8'hDD);
    chk(qpi_active == 1'b0, "R11", "quad left", qpi_active, 0);
    wbuf[0] = 8'h42;
    run_xfer("R11", 8'h03, 1, 1, 1, 1, 1'b0, 8'h00, 1);
  endtask

  task automatic t_bad();
    int h0 = hdr_cnt, w0 = wr_cnt, e0 = evt_cnt, r0 = rr_cnt;
    bit seen, any = 1'b0;
    sel_low();
    send_byte(1, 8'h33, seen);
    for (int k = 0; k < 3; k++) begin
      send_byte(1, 8'hFF, seen);
      if (seen) any = 1'b1;
    end
    sel_high();
    sel_low();
    send_byte(1, 8'h62, seen);
    for (int k = 0; k < 2; k++) begin
      send_byte(1, 8'h00, seen);
      if (seen) any = 1'b1;
    end
    sel_high();
    chk(!any, "R12", "enable on bad command", any, 0);
    chk(hdr_cnt == h0 && wr_cnt == w0 && evt_cnt == e0 && rr_cnt == r0, "R12",
        "strobes on bad command", hdr_cnt - h0 + wr_cnt - w0 + evt_cnt - e0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_writes();
    t_reads();
    t_events();
    t_quad();
    t_abort();
    t_bad();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule